// File: doc/BRIEF.md
# Serial ADC Command and Readback Controller

This block is the host side of a four-wire serial link to a 16-bit successive-approximation converter. A one-cycle start strobe begins a frame. The controller pulls the active-low select line down and shifts out a 16-bit command word, most significant bit first, while it shifts in the 16-bit word the converter returns. The top nibble of the command word is an opcode: one value reads the latest conversion result and the other reads the converter's configuration register. The remaining command bits are sent as zero.

The converter reads command bits on the falling clock edge. It also updates its own output a short time after that same falling edge, and it shows its first bit as soon as select falls. The controller therefore changes its command line one system clock after each falling edge. It samples the returned data a programmable number of system clocks after select falls and after each falling edge, which leaves room for the converter's output delay. The serial clock half-period comes from a divider of the system clock. The clock idles low, and a minimum select-high time is kept between frames. At the end of a frame a one-cycle done pulse presents the received word together with the opcode that was sent. The result code is unsigned straight binary.

Top module: `adc_cmd_spi_host`

## Requirements
- R1: While reset is held and afterwards until the first start, cs_n is 1, sclk is 0, busy is 0 and done is 0.
- R2: A start with op_cfg=0 sends the frame 0xD000 on mosi; a start with op_cfg=1 sends 0xC000. Both are sent MSB first. Bit k is valid from cs_n falling (k=0), or from one clock after the k-th sclk falling edge, until after falling edge k+1, where the slave reads it.
- R3: Each frame has exactly 16 sclk pulses, each high for HALF_DIV clocks. The first rising edge comes HALF_DIV clocks after cs_n falls, and successive rising edges are 2*HALF_DIV clocks apart. sclk is low whenever cs_n is high.
- R4: Received bit k (k=0 is the MSB) is sampled from miso SAMPLE+1 clocks after cs_n falls (k=0), or SAMPLE+1 clocks after the k-th falling edge. SAMPLE is the value of sample_dly.
- R5: cs_n rises HALF_DIV clocks after the 16th falling edge, that is (2*16+1)*HALF_DIV clocks after it fell. done is a one-cycle pulse in the first cycle cs_n is high again.
- R6: rx_word and rx_op take the received word and the opcode sent (0xD or 0xC) when done pulses, and hold them until the next done.
- R7: busy rises the cycle after an accepted start and stays high until cs_n has been high for at least MIN_CS_HIGH clocks. cs_n is never low for a new frame sooner than that.
- R8: A start while busy is ignored. The frame in progress keeps its opcode, and no extra frame follows.
- R9: Any 16-bit pattern, including 0x0000 and 0xFFFF, is captured without bit loss for every sample_dly from 0 to 2*HALF_DIV-1, when the slave's output delay is below sample_dly+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a frame when idle |
| op_cfg | input | 1 | 0 selects the result read, 1 the configuration read |
| sample_dly | input | $clog2(2*HALF_DIV) | Clocks after each falling edge, minus one, before miso is sampled |
| busy | output | 1 | Frame or select-high guard in progress |
| done | output | 1 | One-cycle pulse when the received word is presented |
| rx_word | output | FRAME_BITS | Word received in the last frame |
| rx_op | output | OPC_BITS | Opcode sent in the last frame |
| cs_n | output | 1 | Active-low frame select to the converter |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Data from the converter |

## Verification
The assertions assume that sample_dly stays constant while busy is high, stays within 0 to 2*HALF_DIV-1 when a frame starts, and that start is a clean synchronous input. The bench changes sample_dly only after busy has fallen, and it picks only values inside that range. It matches each value against a slave output delay that is not a whole number of clock periods, so that no miso change falls exactly on a sampling edge. The one start it raises during a frame tests R8 and is not a violation of any assumption.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XFER,
      ST_TAIL,
      ST_GUARD
   } seq_state_t;
endpackage

// File: rtl/adc_spi_timer.sv
module adc_spi_timer #(
   parameter int HALF_DIV   = 4,
   parameter int FRAME_BITS = 16,
   localparam int CW = $clog2(2 * HALF_DIV),
   localparam int IW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   output logic [CW-1:0] cnt,
   output logic          period_end,
   output logic          last_bit,
   output logic          first_tick,
   output logic          sclk
);
   localparam logic [CW-1:0] CNT_RISE = CW'(HALF_DIV - 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(2 * HALF_DIV - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);

   logic [IW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         idx  <= '0;
         sclk <= 1'b0;
      end else if (load) begin
         cnt  <= '0;
         idx  <= '0;
         sclk <= 1'b0;
      end else if (run) begin
         if (cnt == CNT_LAST) begin
            cnt  <= '0;
            idx  <= idx + 1'b1;
            sclk <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_RISE) sclk <= 1'b1;
         end
      end
   end

   assign period_end = run && (cnt == CNT_LAST);
   assign last_bit   = (idx == IDX_LAST);
   assign first_tick = run && (cnt == '0) && (idx != '0);

   // pulses high for exactly HALF_DIV cycles
   logic [CW:0] hi_len;
   always_ff @(posedge clk) begin
      if (!rst_n) hi_len <= '0;
      else if (sclk) hi_len <= hi_len + 1'b1;
      else hi_len <= '0;
   end

   assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> ($past(hi_len) == (CW+1)'(HALF_DIV - 1)));
endmodule

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         shift,
   input  logic         sample,
   input  logic         miso,
   output logic         mosi,
   output logic [W-1:0] rx_shift
);
   logic [W-1:0] tx_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr    <= '0;
         rx_shift <= '0;
      end else begin
         if (load) tx_sr <= load_word;
         else if (shift) tx_sr <= {tx_sr[W-2:0], 1'b0};
         if (sample) rx_shift <= {rx_shift[W-2:0], miso};
      end
   end

   assign mosi = tx_sr[W-1];
endmodule

// File: rtl/adc_cmd_spi_host.sv
module adc_cmd_spi_host #(
   parameter int               HALF_DIV    = 4,
   parameter int               FRAME_BITS  = 16,
   parameter int               OPC_BITS    = 4,
   parameter logic [OPC_BITS-1:0] OPC_RESULT = 4'hD,
   parameter logic [OPC_BITS-1:0] OPC_CONFIG = 4'hC,
   parameter int               MIN_CS_HIGH = 3,
   localparam int DLY_W = $clog2(2 * HALF_DIV)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  op_cfg,
   input  logic [DLY_W-1:0]      sample_dly,
   output logic                  busy,
   output logic                  done,
   output logic [FRAME_BITS-1:0] rx_word,
   output logic [OPC_BITS-1:0]   rx_op,
   output logic                  cs_n,
   output logic                  sclk,
   output logic                  mosi,
   input  logic                  miso
);
   import adc_spi_pkg::*;

   localparam int GMAX = (HALF_DIV > MIN_CS_HIGH) ? HALF_DIV : MIN_CS_HIGH;
   localparam int GW   = $clog2(GMAX + 1);
   localparam logic [GW-1:0] TAIL_END  = GW'(HALF_DIV - 1);
   localparam logic [GW-1:0] GUARD_END = GW'(MIN_CS_HIGH - 1);
   localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'(2 * HALF_DIV - 1);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (FRAME_BITS <= OPC_BITS) begin : g_bad_frame
         $error("FRAME_BITS must exceed OPC_BITS");
      end
      if (MIN_CS_HIGH < 1) begin : g_bad_gap
         $error("MIN_CS_HIGH must be at least 1");
      end
      if (OPC_RESULT == OPC_CONFIG) begin : g_bad_opc
         $error("opcodes must differ");
      end
   endgenerate

   seq_state_t          state;
   logic [GW-1:0]       gcnt;
   logic [OPC_BITS-1:0] op_q;
   logic                accept;
   logic                run;
   logic [DLY_W-1:0]    cnt;
   logic                period_end, last_bit, first_tick;
   logic [FRAME_BITS-1:0] rx_shift;
   logic [FRAME_BITS-1:0] frame_word;
   logic [OPC_BITS-1:0]   op_sel;

   assign accept = start && (state == ST_IDLE);
   assign run    = (state == ST_XFER);
   assign op_sel = op_cfg ? OPC_CONFIG : OPC_RESULT;
   assign frame_word = {op_sel, {(FRAME_BITS - OPC_BITS){1'b0}}};

   adc_spi_timer #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .run(run), .cnt(cnt),
      .period_end(period_end), .last_bit(last_bit), .first_tick(first_tick),
      .sclk(sclk)
   );

   adc_spi_shifter #(.W(FRAME_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_word(frame_word),
      .shift(first_tick), .sample(run && (cnt == sample_dly)), .miso(miso),
      .mosi(mosi), .rx_shift(rx_shift)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         gcnt    <= '0;
         op_q    <= '0;
         cs_n    <= 1'b1;
         done    <= 1'b0;
         rx_word <= '0;
         rx_op   <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_XFER;
                  cs_n  <= 1'b0;
                  op_q  <= op_sel;
               end
            end
            ST_XFER: begin
               if (period_end && last_bit) begin
                  state <= ST_TAIL;
                  gcnt  <= '0;
               end
            end
            ST_TAIL: begin
               if (gcnt == TAIL_END) begin
                  state   <= ST_GUARD;
                  gcnt    <= '0;
                  cs_n    <= 1'b1;
                  done    <= 1'b1;
                  rx_word <= rx_shift;
                  rx_op   <= op_q;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: begin
               if (gcnt == GUARD_END) state <= ST_IDLE;
               else gcnt <= gcnt + 1'b1;
            end
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && !sclk && !done));
   assert_sclk_low_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(cs_n));
   assert_busy_covers_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> busy);
   assert_dly_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sample_dly));
   assert_dly_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (sample_dly <= DLY_MAX));
   assert_op_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_q));
endmodule

// File: tb/tb_adc_cmd_spi_host.sv
`timescale 1ns/1ps
module tb_adc_cmd_spi_host;
   localparam int H    = 4;
   localparam int FB   = 16;
   localparam int GAP  = 3;
   localparam int DW   = $clog2(2 * H);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic op_cfg = 1'b0;
   logic [DW-1:0] sample_dly = '0;
   logic busy, done, cs_n, sclk, mosi;
   logic miso = 1'b0;
   logic [FB-1:0] rx_word;
   logic [3:0] rx_op;

   always #4 clk = ~clk;

   adc_cmd_spi_host #(.HALF_DIV(H), .FRAME_BITS(FB), .MIN_CS_HIGH(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_cfg(op_cfg),
      .sample_dly(sample_dly), .busy(busy), .done(done), .rx_word(rx_word),
      .rx_op(rx_op), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // behavioural converter
   logic [FB-1:0] s_word = '0;
   logic [FB-1:0] s_mosi = '0;
   realtime s_dly = 3.0;
   int s_bit = 0;
   int s_cnt = 0;

   always @(negedge cs_n) begin
      s_bit  = FB - 1;
      s_cnt  = 0;
      s_mosi = '0;
      miso   = s_word[FB-1];
   end

   always @(negedge sclk) begin
      if (!cs_n) begin
         s_mosi = {s_mosi[FB-2:0], mosi};
         s_cnt++;
         s_bit--;
         if (s_bit >= 0) miso <= #(s_dly) s_word[s_bit];
      end
   end

   // scoreboard
   typedef struct { logic [3:0] op; logic [FB-1:0] word; } exp_t;
   exp_t q[$];
   int frames_sent = 0;
   int cs_falls = 0;

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) begin
            chk(0, "R8", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(rx_word == e.word, "R9", "rx_word", rx_word, e.word);
            chk(rx_op == e.op, "R6", "rx_op", rx_op, e.op);
            chk(s_mosi == {e.op, 12'h000}, "R2", "mosi frame", s_mosi, {e.op, 12'h000});
            chk(s_cnt == FB, "R3", "falling edge count", s_cnt, FB);
         end
      end
   end

   // line timing monitor
   bit prev_cs = 1'b1, prev_sclk = 1'b0, had_frame = 1'b0;
   int since_cs = 0, pulses = 0, cs_hi = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n && prev_cs) begin
            cs_falls++;
            if (had_frame) chk(cs_hi >= GAP, "R7", "cs_n high time", cs_hi, GAP);
            since_cs = 0;
            pulses   = 0;
         end
         if (!cs_n) since_cs++;
         if (sclk && !prev_sclk) begin
            pulses++;
            chk(since_cs - 1 == H + 2 * H * (pulses - 1), "R3", "sclk rise time",
                since_cs - 1, H + 2 * H * (pulses - 1));
         end
         if (sclk && cs_n) chk(0, "R3", "sclk high while deselected", 1, 0);
         if (cs_n && !prev_cs) begin
            had_frame = 1'b1;
            cs_hi = 0;
            chk(pulses == FB, "R3", "pulse count", pulses, FB);
            chk(since_cs == (2 * FB + 1) * H, "R5", "cs_n low time", since_cs,
                (2 * FB + 1) * H);
            chk(done == 1'b1, "R5", "done on release", done, 1);
         end else if (done) begin
            chk(0, "R5", "done not on release", 0, 1);
         end
         if (cs_n) cs_hi++;
         prev_cs   = cs_n;
         prev_sclk = sclk;
      end
   end

   task automatic run_frame(input bit cfg, input logic [FB-1:0] word);
      exp_t e;
      while (busy) @(negedge clk);
      e.op   = cfg ? 4'hC : 4'hD;
      e.word = word;
      q.push_back(e);
      s_word = word;
      op_cfg = cfg;
      start  = 1'b1;
      frames_sent++;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R7", "busy after start", busy, 1);
   endtask

   task automatic set_timing(input int dly, input realtime sdly);
      while (busy) @(negedge clk);
      sample_dly = DW'(dly);
      s_dly = sdly;
   endtask

   task automatic run_tests();
      repeat (3) @(negedge clk);
      chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "lines in reset",
          {cs_n, sclk, busy, done}, 4'b1000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "lines after reset",
          {cs_n, sclk, busy, done}, 4'b1000);

      set_timing(0, 3.0);
      run_frame(0, 16'h0000);
      run_frame(1, 16'hFFFD);
      run_frame(0, 16'hFFFF);
      set_timing(2, 20.0);
      run_frame(0, 16'hA5C3);
      run_frame(1, 16'h8001);
      set_timing(7, 50.0);
      run_frame(0, 16'h5AA5);
      run_frame(1, 16'h1234);

      // R8: a start raised mid-frame with the other opcode
      set_timing(1, 5.0);
      run_frame(0, 16'hC0DE);
      repeat (40) @(negedge clk);
      op_cfg = 1'b1;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      op_cfg = 1'b0;
      while (busy) @(negedge clk);
      chk(rx_op == 4'hD, "R8", "opcode kept", rx_op, 4'hD);
      repeat (30) @(negedge clk);
      chk(cs_falls == frames_sent, "R8", "frame count", cs_falls, frames_sent);
      chk(q.size() == 0, "R6", "all results delivered", q.size(), 0);
      chk(rx_word == 16'hC0DE, "R6", "rx_word held", rx_word, 16'hC0DE);
      chk(busy == 0 && cs_n == 1, "R7", "idle at end", {busy, cs_n}, 2'b01);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            chk(0, "R1", "watchdog expired", 1, 0);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule